// File: doc/BRIEF.md
# Serial Flash Device Command Engine

A synthesizable device-side model of a small serial flash memory. The host reaches it through a serial clock, a data input and a data output, with an active-low chip select. An active-low write-protect input and an active-low hardware reset are also provided. The block turns the serial stream into 8-bit bus cycles: an opcode, then address bytes and data bytes. It decodes read, byte-program, sector-erase, chip-erase, status-read and identification-read commands, and it drives the serial output during the phases that return data.

Program and erase run as self-timed operations. Each command loads a busy counter whose length is a parameter, and the array changes only when that count runs out. The storage is a register array that is much smaller than a real part, so simulation stays fast. The serial pins are sampled by the block's own system clock. The host must hold the serial clock at least two system clocks in each phase and must idle it low.

Top module: `fsd_engine`

## Requirements
- R1: Every bus cycle is 8 bits, taken most significant bit first on rising serial-clock edges while chip select is low. Chip select high clears the bit position, so a partial byte is dropped.
- R2: `sdo` changes only on the system clock after a falling serial-clock edge is seen. `sdo_oe` rises only at the start of an output byte in an output phase, and it is low one system clock after chip select is high.
- R3: Read is opcode 03H followed by three address bytes, high byte first. The low ADDR_W bits of the 24-bit value are used. Bytes then stream from that address, incrementing after each byte and wrapping from the top address to 0, until chip select rises.
- R4: Byte program is opcode 10H, three address bytes, then one data byte. After PROG_CYC system clocks, the stored byte becomes old AND new, so programming only clears bits.
- R5: Sector erase is opcode 20H plus three address bytes. After SERASE_CYC clocks, every byte of the 2^SECT_W-byte sector holding that address reads FFH, and other sectors keep their contents.
- R6: Chip erase is opcode 60H alone. After CERASE_CYC clocks, every byte reads FFH.
- R7: Status read is opcode 9FH. It returns 01H when idle and 00H while a program or erase runs, with bit 0 meaning ready. It repeats a fresh byte for as long as the clock runs.
- R8: Identification read is opcode 90H. It returns BFH then 42H, and the two bytes alternate for as long as the clock runs.
- R9: With `wp_n` low when a program or erase would start, nothing starts: status stays ready and the array is unchanged.
- R10: While busy, every opcode except status read is ignored and gives no output.
- R11: A chip-select rise before the last byte of a program or sector erase aborts it, and no operation starts.
- R12: `rst_n` low returns the block to standby and drops any running operation without changing the array. After reset, `sdo_oe` is low and status reads ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Active-low write protect |
| sdo | output | 1 | Serial data out of the device |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
Two things can land on the same system clock: the busy counter expiring and committing an erase, and the status engine loading the next status byte for the output shifter. The bench provokes this by holding chip select low through a whole chip erase and streaming status bytes. It requires that the first byte is 00H, that every byte is 00H or 01H, and that once 01H appears no 00H follows. A full read straight after that stream must show the committed result. A second overlap, the read pointer wrapping at the top address on the same clock as a byte boundary, is judged by streaming past the top address and comparing every byte against an arithmetic mirror of the array.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_PROG   = 8'h10;
    localparam logic [7:0] OPC_SERASE = 8'h20;
    localparam logic [7:0] OPC_CERASE = 8'h60;
    localparam logic [7:0] OPC_STAT   = 8'h9F;
    localparam logic [7:0] OPC_IDNT   = 8'h90;

    localparam logic [7:0] ID_MFR = 8'hBF;
    localparam logic [7:0] ID_DEV = 8'h42;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_STAT,
        PH_IDNT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        JOB_NONE,
        JOB_PROG,
        JOB_SERASE,
        JOB_CERASE
    } job_e;

endpackage

// File: rtl/fsd_serial_rx.sv
module fsd_serial_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdi,
    output logic       rise,
    output logic       fall,
    output logic [2:0] bit_idx,
    output logic       byte_stb,
    output logic [7:0] byte_val
);

    typedef struct packed {
        logic       sclk;
        logic [2:0] bit_idx;
        logic [6:0] sr;
    } rx_state_t;

    rx_state_t q, d;

    always_comb begin
        d        = q;
        rise     = !cs_n && sclk && !q.sclk;
        fall     = !cs_n && !sclk && q.sclk;
        byte_stb = rise && (q.bit_idx == 3'd7);
        byte_val = {q.sr, sdi};
        bit_idx  = q.bit_idx;
        d.sclk   = sclk;
        if (cs_n) begin
            d.bit_idx = '0;
        end else if (rise) begin
            d.sr      = {q.sr[5:0], sdi};
            d.bit_idx = q.bit_idx + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/fsd_busy_timer.sv
module fsd_busy_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t q, d;

    always_comb begin
        d    = q;
        busy = (q.cnt != '0);
        done = (q.cnt == CNT_W'(1));
        if (start)     d.cnt = load_val;
        else if (busy) d.cnt = q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/fsd_cell_array.sv
module fsd_cell_array #(
    parameter int ADDR_W = 9,
    parameter int SECT_W = 7,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int SIDX_W = ADDR_W - SECT_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              sect_clr,
    input  logic [SIDX_W-1:0] sect_idx,
    input  logic              chip_clr
);

    logic [7:0] cells [DEPTH];

    assign rd_data = cells[rd_addr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (chip_clr || (sect_clr && (SIDX_W'(i >> SECT_W) == sect_idx))) begin
                cells[i] <= 8'hFF;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                cells[i] <= cells[i] & wr_data;
            end
        end
    end

endmodule

// File: rtl/fsd_engine.sv
module fsd_engine #(
    parameter int ADDR_W     = 9,
    parameter int SECT_W     = 7,
    parameter int PROG_CYC   = 200,
    parameter int SERASE_CYC = 400,
    parameter int CERASE_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    input  logic wp_n,
    output logic sdo,
    output logic sdo_oe
);
    import fsd_pkg::*;

    localparam int MAX_A   = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
    localparam int MAX_CYC = (MAX_A > CERASE_CYC) ? MAX_A : CERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int SIDX_W  = ADDR_W - SECT_W;

    typedef struct packed {
        phase_e            phase;
        logic [1:0]        nbytes;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] ad;
        job_e              job;
        logic [ADDR_W-1:0] job_addr;
        logic [7:0]        job_data;
        logic [7:0]        osr;
        logic              sdo;
        logic              oe;
        logic              id_sel;
    } eng_state_t;

    eng_state_t q, d;

    logic       rx_rise, rx_fall, byte_stb;
    logic [2:0] bit_idx;
    logic [7:0] byte_val;
    logic       job_start, timer_busy, timer_done;
    logic [CNT_W-1:0] job_len;
    logic [7:0] rd_data, tx_byte;
    logic       out_phase;

    fsd_serial_rx rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .rise     (rx_rise),
        .fall     (rx_fall),
        .bit_idx  (bit_idx),
        .byte_stb (byte_stb),
        .byte_val (byte_val)
    );

    fsd_busy_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (job_start),
        .load_val (job_len),
        .busy     (timer_busy),
        .done     (timer_done)
    );

    fsd_cell_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) arr_i (
        .clk      (clk),
        .rd_addr  (q.ad),
        .rd_data  (rd_data),
        .wr_en    (timer_done && (q.job == JOB_PROG)),
        .wr_addr  (q.job_addr),
        .wr_data  (q.job_data),
        .sect_clr (timer_done && (q.job == JOB_SERASE)),
        .sect_idx (q.job_addr[ADDR_W-1:SECT_W]),
        .chip_clr (timer_done && (q.job == JOB_CERASE))
    );

    // byte presented at the start of the current output slot
    always_comb begin
        unique case (q.phase)
            PH_READ: tx_byte = rd_data;
            PH_STAT: tx_byte = {7'b0, !timer_busy};
            PH_IDNT: tx_byte = q.id_sel ? ID_DEV : ID_MFR;
            default: tx_byte = 8'h00;
        endcase
        out_phase = (q.phase == PH_READ) || (q.phase == PH_STAT) || (q.phase == PH_IDNT);
    end

    always_comb begin
        d         = q;
        job_start = 1'b0;
        job_len   = '0;

        if (timer_done) d.job = JOB_NONE;

        if (byte_stb) begin
            unique case (q.phase)
                PH_OPC: begin
                    d.opc    = byte_val;
                    d.nbytes = '0;
                    d.phase  = PH_SKIP;
                    if (!timer_busy || byte_val == OPC_STAT) begin
                        unique case (byte_val)
                            OPC_READ, OPC_PROG, OPC_SERASE: d.phase = PH_ADDR;
                            OPC_STAT:  d.phase = PH_STAT;
                            OPC_IDNT: begin
                                d.phase  = PH_IDNT;
                                d.id_sel = 1'b0;
                            end
                            OPC_CERASE: begin
                                if (wp_n) begin
                                    job_start = 1'b1;
                                    job_len   = CNT_W'(CERASE_CYC);
                                    d.job     = JOB_CERASE;
                                end
                            end
                            default: d.phase = PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR: begin
                    d.ad     = {q.ad[ADDR_W-9:0], byte_val};
                    d.nbytes = q.nbytes + 2'd1;
                    if (q.nbytes == 2'd2) begin
                        if (q.opc == OPC_READ) begin
                            d.phase = PH_READ;
                        end else if (q.opc == OPC_PROG) begin
                            d.phase = PH_DATA;
                        end else begin
                            d.phase = PH_SKIP;
                            if (wp_n) begin
                                job_start  = 1'b1;
                                job_len    = CNT_W'(SERASE_CYC);
                                d.job      = JOB_SERASE;
                                d.job_addr = {q.ad[ADDR_W-9:0], byte_val};
                            end
                        end
                    end
                end
                PH_DATA: begin
                    d.phase = PH_SKIP;
                    if (wp_n) begin
                        job_start  = 1'b1;
                        job_len    = CNT_W'(PROG_CYC);
                        d.job      = JOB_PROG;
                        d.job_addr = q.ad;
                        d.job_data = byte_val;
                    end
                end
                PH_READ: d.ad     = q.ad + ADDR_W'(1);
                PH_IDNT: d.id_sel = !q.id_sel;
                default: ;
            endcase
        end

        if (rx_fall) begin
            if (bit_idx == 3'd0) begin
                d.osr = {tx_byte[6:0], 1'b0};
                d.sdo = tx_byte[7];
                if (out_phase) d.oe = 1'b1;
            end else begin
                d.osr = {q.osr[6:0], 1'b0};
                d.sdo = q.osr[7];
            end
        end

        if (cs_n) begin
            d.phase = PH_OPC;
            d.oe    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_OPC;
            q.job   <= JOB_NONE;
        end else begin
            q <= d;
        end
    end

    assign sdo    = q.sdo;
    assign sdo_oe = q.oe;

endmodule

// File: rtl/fsd_engine_chk.sv
module fsd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic wp_n,
    input logic sdo,
    input logic sdo_oe,
    input logic start,
    input logic busy
);

    // R2: output enable drops once chip select has been high for a clock
    a_r2_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !sdo_oe);

    // R2: data output moves only after a falling serial clock
    a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> ($past(sclk, 2) && !$past(sclk)));

    // R9: nothing self-timed starts under write protect
    a_r9_no_start_protected: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wp_n);

    // R10: no new operation starts while one is running
    a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R11: an operation only starts inside a selected command
    a_r11_start_selected: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !cs_n);

endmodule

bind fsd_engine fsd_engine_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .wp_n   (wp_n),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .start  (job_start),
    .busy   (timer_busy)
);

// File: tb/fsd_engine_tb.sv
module fsd_engine_tb_top;

    localparam int ADDR_W = 9;
    localparam int SECT_W = 7;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic wp_n = 1'b1;
    logic sdo, sdo_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [DEPTH];

    always #2 clk = ~clk;

    fsd_engine #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(200),
                 .SERASE_CYC(400), .CERASE_CYC(600)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .wp_n(wp_n), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            sdi  = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic send_addr(input int a);
        logic [7:0] rx;
        xfer(8'h00, rx);
        xfer(8'((a >> 8) & 8'hFF), rx);
        xfer(8'(a & 8'hFF), rx);
    endtask

    task automatic cmd_prog(input int a, input logic [7:0] v);
        logic [7:0] rx;
        sel(); xfer(8'h10, rx); send_addr(a); xfer(v, rx); desel();
    endtask

    task automatic cmd_serase(input int a);
        logic [7:0] rx;
        sel(); xfer(8'h20, rx); send_addr(a); desel();
    endtask

    task automatic cmd_cerase();
        logic [7:0] rx;
        sel(); xfer(8'h60, rx); desel();
    endtask

    task automatic status(output logic [7:0] st);
        logic [7:0] rx;
        sel(); xfer(8'h9F, rx); xfer(8'h00, st); desel();
    endtask

    task automatic wait_ready();
        logic [7:0] st;
        for (int n = 0; n < 100; n++) begin
            status(st);
            if (st == 8'h01) break;
        end
    endtask

    task automatic read_cmp(input int a, input int n, input string tag);
        logic [7:0] rx;
        sel(); xfer(8'h03, rx); send_addr(a);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, rx);
            check(rx == exp_mem[(a + i) % DEPTH], tag, rx, exp_mem[(a + i) % DEPTH]);
        end
        check(sdo_oe == 1'b1, "R2 oe during read", sdo_oe, 1);
        desel();
        check(sdo_oe == 1'b0, "R2 oe after deselect", sdo_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, rx;
        bit seen_ready, mono;
        int a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 reset state
        check(sdo_oe == 1'b0, "R12 oe after reset", sdo_oe, 0);
        status(st);
        check(st == 8'h01, "R12 ready after reset", st, 1);

        // R6/R7: chip erase with continuous status stream through the busy window
        cmd_cerase();
        sel(); xfer(8'h9F, rx);
        xfer(8'h00, st);
        check(st == 8'h00, "R7 busy status", st, 0);
        seen_ready = 1'b0; mono = 1'b1;
        for (int n = 0; n < 40; n++) begin
            xfer(8'h00, st);
            if (st != 8'h00 && st != 8'h01) mono = 1'b0;
            if (seen_ready && st == 8'h00) mono = 1'b0;
            if (st == 8'h01) seen_ready = 1'b1;
        end
        desel();
        check(mono, "R7 status stream monotone", mono, 1);
        check(seen_ready, "R7 status becomes ready", seen_ready, 1);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        read_cmp(0, DEPTH, "R6 chip erase all FF");

        // R4: program sweep
        for (int k = 0; k < 64; k++) begin
            a = k * 8 + (k & 7);
            cmd_prog(a, 8'((a * 29 + 7) & 255));
            exp_mem[a] = 8'((a * 29 + 7) & 255);
            wait_ready();
        end
        // R3: stream across the top address
        read_cmp(DEPTH - 12, DEPTH + 8, "R3 read wrap");

        // R4: AND of two programs
        cmd_prog(3, 8'hF0); wait_ready();
        cmd_prog(3, 8'h3C); wait_ready();
        exp_mem[3] = 8'h30;
        read_cmp(3, 1, "R4 program ANDs");

        // R9: write protect
        wp_n = 1'b0;
        cmd_prog(5, 8'h00);
        status(st); check(st == 8'h01, "R9 prog not started", st, 1);
        cmd_serase(5);
        status(st); check(st == 8'h01, "R9 erase not started", st, 1);
        cmd_cerase();
        status(st); check(st == 8'h01, "R9 chip erase not started", st, 1);
        wp_n = 1'b1;
        read_cmp(0, 16, "R9 array unchanged");

        // R10: commands ignored while busy
        cmd_prog(6, 8'h0F);
        cmd_prog(7, 8'h00);
        wait_ready();
        exp_mem[6] = 8'h0F;
        read_cmp(6, 2, "R10 second program ignored");
        cmd_prog(12, 8'hA5);
        sel(); xfer(8'h03, rx); send_addr(0); xfer(8'h00, rx);
        check(sdo_oe == 1'b0, "R10 read ignored while busy", sdo_oe, 0);
        desel();
        wait_ready();
        exp_mem[12] = 8'hA5;
        read_cmp(12, 1, "R10 busy program lands");

        // R11: aborted commands
        sel(); xfer(8'h10, rx); xfer(8'h00, rx); xfer(8'h00, rx); desel();
        status(st); check(st == 8'h01, "R11 abort in address", st, 1);
        sel(); xfer(8'h10, rx); send_addr(20); desel();
        status(st); check(st == 8'h01, "R11 abort before data", st, 1);
        sel(); xfer(8'h20, rx); xfer(8'h00, rx); desel();
        status(st); check(st == 8'h01, "R11 abort erase", st, 1);
        read_cmp(16, 8, "R11 array unchanged");

        // R1: partial byte dropped at deselect
        sel();
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0; sdi = 1'b1; repeat (HALF) @(negedge clk);
            sclk = 1'b1; repeat (HALF) @(negedge clk);
        end
        desel();
        status(st); check(st == 8'h01, "R1 framing restarts", st, 1);

        // R5: sector erase of sector 1
        cmd_serase(12'h0C5);
        wait_ready();
        for (int i = 0; i < DEPTH; i++)
            if ((i >> SECT_W) == 1) exp_mem[i] = 8'hFF;
        read_cmp(0, DEPTH, "R5 sector erase");

        // R12: reset mid chip erase
        cmd_cerase();
        repeat (50) @(negedge clk);
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo_oe == 1'b0, "R12 oe after reset", sdo_oe, 0);
        status(st); check(st == 8'h01, "R12 op dropped", st, 1);
        read_cmp(0, 24, "R12 array kept");

        // R8: identification
        sel(); xfer(8'h90, rx);
        for (int i = 0; i < 5; i++) begin
            xfer(8'h00, rx);
            check(rx == ((i % 2 == 0) ? 8'hBF : 8'h42), "R8 id bytes", rx,
                  (i % 2 == 0) ? 8'hBF : 8'h42);
        end
        desel();

        // R7: status repeats while idle
        sel(); xfer(8'h9F, rx);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, st);
            check(st == 8'h01, "R7 repeat", st, 1);
        end
        desel();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule